// File: doc/BRIEF.md
# Link Bring-Up and Speed-Upgrade Sequencer

This block starts a serial link at the first generation and moves it to the second generation once the link trains. On a start pulse it limits the link's maximum-speed field to generation 1. It then enables training and waits for a qualified link-up. A link-up counts only when the up indication is set and the in-training indication is clear. When that happens the block raises the cap to generation 2 and issues a one-cycle directed speed-change request. The speed-change flag clears by itself when the change completes, and the block waits for that. It then waits for a qualified link-up a second time and reports the outcome. Each wait ends in failure when its cycle budget runs out.

While waiting for the link, the block also looks for a speed change that has stalled in receiver lock. In that state the receiver never signals valid data. When it finds this case, it drives the PHY receiver data-enable and PLL-enable overrides for a fixed number of cycles and then resumes waiting. Every time interval is a parameter counted in clock cycles.

States: IDLE (wait for start), CAP (cap set to generation 1, training off), LWAIT (evaluate the link), RECHK (spacing before the next link check), RXRST (receiver override pulse), RAISE (cap set to 2, request issued), SWAIT (wait for the flag to clear), PASS and FAIL (result held). Transitions are: start from IDLE, PASS or FAIL to CAP; CAP to LWAIT; LWAIT to RAISE, PASS, FAIL, RECHK or RXRST, in that priority; RECHK and RXRST back to LWAIT when their interval ends; RAISE to SWAIT; SWAIT to LWAIT when the flag clears, or to FAIL on timeout.

Top module: `lnk_speedup_ctrl`

## Requirements
- R1: After reset, max_speed_o is 1 and every other output is 0.
- R2: Start is accepted in IDLE, PASS or FAIL. For one cycle training stays off with the cap at 1, and training is then enabled while the cap is still 1.
- R3: A link check passes only when link_up_i=1 and in_training_i=0. When the link is up but still training, the next check follows after RECHK_CYC cycles. Up to RECHK_MAX such rechecks run before stall evaluation is allowed.
- R4: On the first passing check, max_speed_o becomes 2 and spd_chg_req_o is high for exactly one cycle. That cycle is the second cycle after the start edge when the link is already ready.
- R5: A link wait that has not passed within LINK_WAIT_CYC cycles ends in FAIL, with done_o visible LINK_WAIT_CYC+2 cycles after the start edge. A check that passes in the expiring cycle still wins.
- R6: After the request, the block waits for spd_flag_i=0 and then for a passing link check, and reports pass. If the flag is still 1 after SPD_WAIT_CYC cycles, the result is FAIL.
- R7: done_o stays high from the end of the sequence until the next start. pass_o reports the result. speed_o holds cur_speed_i as captured on the passing check, and it is 0 after a failure.
- R8: A stall exists when the link check did not pass, no recheck is pending, rx_valid_i=0 and ltssm_i equals 6'h0D. Both override outputs then go high together for exactly HOLD_CYC cycles, and waiting resumes.
- R9: When rx_valid_i=1 or ltssm_i differs from 6'h0D, the overrides stay low.
- R10: A start pulse while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a bring-up sequence |
| link_up_i | input | 1 | Link reports up |
| in_training_i | input | 1 | Link still in training |
| spd_flag_i | input | 1 | Self-clearing speed-change flag |
| cur_speed_i | input | 4 | Current link speed |
| rx_valid_i | input | 1 | PHY receiver reports valid data |
| ltssm_i | input | 6 | Training state code |
| max_speed_o | output | 4 | Maximum-speed cap (1 or 2) |
| train_en_o | output | 1 | Training enable |
| spd_chg_req_o | output | 1 | Directed speed-change request pulse |
| rx_data_ovrd_o | output | 1 | Receiver data-enable override |
| rx_pll_ovrd_o | output | 1 | Receiver PLL-enable override |
| done_o | output | 1 | Sequence finished |
| pass_o | output | 1 | Sequence succeeded |
| speed_o | output | 4 | Reported negotiated speed |

## Verification
Two cases can arise in the same LWAIT cycle. First, the stall condition can hold while the link is up but still training, so a recheck and a receiver reset compete. The bench holds up, training and the stall code constant, and expects the first override cycle exactly after RECHK_MAX recheck windows. Second, the link budget can expire in the very cycle the link qualifies. The bench raises link-up one cycle before the expiry and expects a speed-change request rather than a failure.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAP,
        ST_LWAIT,
        ST_RECHK,
        ST_RXRST,
        ST_RAISE,
        ST_SWAIT,
        ST_PASS,
        ST_FAIL
    } lnk_state_e;

    localparam logic [3:0] SPD_GEN1       = 4'd1;
    localparam logic [3:0] SPD_GEN2       = 4'd2;
    localparam logic [5:0] RCVR_LOCK_CODE = 6'h0D;
endpackage

// File: rtl/lnk_timer.sv
module lnk_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    // saturating up-counter, restarted by clr_i
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= '0;
        else if (cnt_o != {W{1'b1}})
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/lnk_status_eval.sv
module lnk_status_eval
    import lnk_pkg::*;
(
    input  logic       link_up_i,
    input  logic       in_training_i,
    input  logic       rx_valid_i,
    input  logic [5:0] ltssm_i,
    output logic       ready_o,
    output logic       up_training_o,
    output logic       stall_o
);
    always_comb begin
        ready_o       = link_up_i && !in_training_i;
        up_training_o = link_up_i && in_training_i;
        stall_o       = !rx_valid_i && (ltssm_i == RCVR_LOCK_CODE);
    end
endmodule

// File: rtl/lnk_speedup_ctrl.sv
module lnk_speedup_ctrl
    import lnk_pkg::*;
#(
    parameter int LINK_WAIT_CYC = 125_000_000,
    parameter int SPD_WAIT_CYC  = 125_000_000,
    parameter int RECHK_CYC     = 125_000,
    parameter int RECHK_MAX     = 5,
    parameter int HOLD_CYC      = 250_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       link_up_i,
    input  logic       in_training_i,
    input  logic       spd_flag_i,
    input  logic [3:0] cur_speed_i,
    input  logic       rx_valid_i,
    input  logic [5:0] ltssm_i,
    output logic [3:0] max_speed_o,
    output logic       train_en_o,
    output logic       spd_chg_req_o,
    output logic       rx_data_ovrd_o,
    output logic       rx_pll_ovrd_o,
    output logic       done_o,
    output logic       pass_o,
    output logic [3:0] speed_o
);
    localparam int LONG_MAX  = (LINK_WAIT_CYC > SPD_WAIT_CYC) ? LINK_WAIT_CYC : SPD_WAIT_CYC;
    localparam int SHORT_MAX = (RECHK_CYC > HOLD_CYC) ? RECHK_CYC : HOLD_CYC;
    localparam int TW = $clog2(LONG_MAX + 1) + 1;
    localparam int SW = $clog2(SHORT_MAX + 1) + 1;
    localparam int RW = $clog2(RECHK_MAX + 1) + 1;
    localparam logic [TW-1:0] LINK_LIM  = TW'(LINK_WAIT_CYC);
    localparam logic [TW-1:0] SPD_LIM   = TW'(SPD_WAIT_CYC);
    localparam logic [SW-1:0] RECHK_END = SW'(RECHK_CYC - 1);
    localparam logic [SW-1:0] HOLD_END  = SW'(HOLD_CYC - 1);
    localparam logic [RW-1:0] RC_LIM    = RW'(RECHK_MAX);

    lnk_state_e     st, nxt;
    logic           ready, up_trn, stall;
    logic           t_clr, s_clr;
    logic [TW-1:0]  t_cnt;
    logic [SW-1:0]  s_cnt;
    logic [RW-1:0]  rc_q;
    logic           trn_q, raised_q;
    logic [3:0]     speed_q;
    logic           accept;

    lnk_status_eval u_eval (
        .link_up_i     (link_up_i),
        .in_training_i (in_training_i),
        .rx_valid_i    (rx_valid_i),
        .ltssm_i       (ltssm_i),
        .ready_o       (ready),
        .up_training_o (up_trn),
        .stall_o       (stall)
    );

    // phase budget timer (link waits and flag wait)
    lnk_timer #(.W(TW)) u_phase_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (t_clr),
        .cnt_o (t_cnt)
    );

    // interval timer (recheck spacing and override hold)
    lnk_timer #(.W(SW)) u_gap_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (s_clr),
        .cnt_o (s_cnt)
    );

    assign accept = start_i && ((st == ST_IDLE) || (st == ST_PASS) || (st == ST_FAIL));
    assign t_clr  = (st == ST_CAP) || (st == ST_RAISE) || ((st == ST_SWAIT) && (nxt == ST_LWAIT));
    assign s_clr  = (st == ST_LWAIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE, ST_PASS, ST_FAIL: if (start_i) nxt = ST_CAP;
            ST_CAP:   nxt = ST_LWAIT;
            ST_LWAIT: begin
                if (ready)
                    nxt = raised_q ? ST_PASS : ST_RAISE;
                else if (t_cnt >= LINK_LIM)
                    nxt = ST_FAIL;
                else if (up_trn && (rc_q < RC_LIM))
                    nxt = ST_RECHK;
                else if (stall)
                    nxt = ST_RXRST;
            end
            ST_RECHK: if (s_cnt >= RECHK_END) nxt = ST_LWAIT;
            ST_RXRST: if (s_cnt >= HOLD_END) nxt = ST_LWAIT;
            ST_RAISE: nxt = ST_SWAIT;
            ST_SWAIT: begin
                if (!spd_flag_i)
                    nxt = ST_LWAIT;
                else if (t_cnt >= SPD_LIM)
                    nxt = ST_FAIL;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // sequence bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trn_q    <= 1'b0;
            raised_q <= 1'b0;
            speed_q  <= '0;
            rc_q     <= '0;
        end else begin
            if (accept) begin
                trn_q    <= 1'b0;
                raised_q <= 1'b0;
                speed_q  <= '0;
            end
            if (st == ST_CAP)
                trn_q <= 1'b1;
            if ((st == ST_LWAIT) && (nxt == ST_RAISE))
                raised_q <= 1'b1;
            if ((st == ST_LWAIT) && (nxt == ST_PASS))
                speed_q <= cur_speed_i;
            if ((st == ST_CAP) || (st == ST_SWAIT))
                rc_q <= '0;
            else if ((st == ST_LWAIT) && ((nxt == ST_RXRST) || (rc_q >= RC_LIM)))
                rc_q <= '0;
            else if ((st == ST_RECHK) && (nxt == ST_LWAIT))
                rc_q <= rc_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        max_speed_o    = raised_q ? SPD_GEN2 : SPD_GEN1;
        train_en_o     = trn_q;
        spd_chg_req_o  = (st == ST_RAISE);
        rx_data_ovrd_o = (st == ST_RXRST);
        rx_pll_ovrd_o  = (st == ST_RXRST);
        done_o         = (st == ST_PASS) || (st == ST_FAIL);
        pass_o         = (st == ST_PASS);
        speed_o        = speed_q;
    end

    AST_TRAIN_AT_GEN1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> (max_speed_o == SPD_GEN1)); // R2
    AST_REQ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spd_chg_req_o) |-> $past(link_up_i && !in_training_i)); // R3
    AST_REQ_AT_GEN2: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_req_o |-> (max_speed_o == SPD_GEN2)); // R4
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_req_o |=> !spd_chg_req_o); // R4
    AST_FAIL_NO_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pass_o) |-> (speed_o == 4'd0)); // R7
    AST_OVRD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_ovrd_o == rx_pll_ovrd_o); // R8
    AST_OVRD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_data_ovrd_o) |-> $past(!rx_valid_i && (ltssm_i == RCVR_LOCK_CODE))); // R9
endmodule

// File: tb/tb_lnk_speedup_ctrl.sv
module tb_lnk_speedup_ctrl;
    localparam int LINK = 200;
    localparam int SPDW = 100;
    localparam int RC   = 8;
    localparam int RMAX = 5;
    localparam int HOLD = 12;
    localparam int MAXC = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic manual = 1'b1;
    logic m_up = 1'b0, m_trn = 1'b0;
    logic a_up = 1'b0;
    logic flag = 1'b0, fclr = 1'b0;
    logic [3:0] cur_speed = 4'd0;
    logic rx_valid = 1'b1;
    logic [5:0] ltssm = 6'h11;
    logic link_up, in_trn;
    logic [3:0] max_speed, speed;
    logic train_en, spd_req, ov_data, ov_pll, done, pass;

    int checks = 0, fails = 0;
    int up_dly = -1, flag_dly = 5, tcnt = 0, fcnt = 0;
    int r_req_n, r_ov_n, r_done_n, r_req_cnt, r_ov_cyc, r_burst, r_pass, r_speed, r_cap, r_req_max;
    bit finished = 0;

    always #10 clk = ~clk;

    assign link_up = manual ? m_up : a_up;
    assign in_trn  = manual ? m_trn : 1'b0;

    lnk_speedup_ctrl #(
        .LINK_WAIT_CYC(LINK), .SPD_WAIT_CYC(SPDW), .RECHK_CYC(RC),
        .RECHK_MAX(RMAX), .HOLD_CYC(HOLD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .link_up_i(link_up),
        .in_training_i(in_trn), .spd_flag_i(flag), .cur_speed_i(cur_speed),
        .rx_valid_i(rx_valid), .ltssm_i(ltssm), .max_speed_o(max_speed),
        .train_en_o(train_en), .spd_chg_req_o(spd_req), .rx_data_ovrd_o(ov_data),
        .rx_pll_ovrd_o(ov_pll), .done_o(done), .pass_o(pass), .speed_o(speed)
    );

    // link partner model: auto link-up and self-clearing flag
    always @(posedge clk) begin
        if (!train_en) tcnt <= 0; else tcnt <= tcnt + 1;
        a_up <= train_en && (up_dly >= 0) && (tcnt >= up_dly);
        if (fclr) flag <= 1'b0;
        else if (spd_req) begin flag <= 1'b1; fcnt <= 0; end
        else if (flag && flag_dly >= 0) begin
            if (fcnt + 1 >= flag_dly) flag <= 1'b0;
            fcnt <= fcnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_pass(input int ud, input int fd);
        return (ud >= 0 && fd >= 0) ? 1 : 0;
    endfunction

    task automatic run_seq(input int trn_off_at, input int busy_at, input int up_at);
        bit burst_closed = 0;
        r_req_n = -1; r_ov_n = -1; r_done_n = -1; r_req_cnt = 0; r_ov_cyc = 0;
        r_burst = 0; r_pass = -1; r_speed = -1; r_cap = -1; r_req_max = -1;
        @(negedge clk); start = 1'b1; fclr = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0; fclr = 1'b0;
        for (int n = 1; n <= MAXC; n++) begin
            @(posedge clk); @(negedge clk);
            if (train_en && r_cap < 0) r_cap = max_speed;
            if (spd_req) begin
                r_req_cnt++;
                if (r_req_n < 0) begin r_req_n = n; r_req_max = max_speed; end
            end
            if (ov_data) begin
                r_ov_cyc++;
                if (r_ov_n < 0) r_ov_n = n;
                if (!burst_closed) r_burst++;
            end else if (r_burst > 0) burst_closed = 1;
            if (ov_data != ov_pll) chk("R8 override pair", ov_pll, ov_data);
            if (n == trn_off_at) m_trn = 1'b0;
            if (n == up_at) m_up = 1'b1;
            start = (n == busy_at);
            if (done) begin
                r_done_n = n; r_pass = pass; r_speed = speed;
                break;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R5 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 max_speed", max_speed, 1);
        chk("R1 train_en", train_en, 0);
        chk("R1 req", spd_req, 0);
        chk("R1 override", ov_data, 0);
        chk("R1 done", done, 0);
        chk("R1 pass", pass, 0);
        chk("R1 speed", speed, 0);

        // ready link, clean flow
        manual = 1; m_up = 1; m_trn = 0; rx_valid = 1; ltssm = 6'h11;
        cur_speed = 4'd2; flag_dly = 5;
        run_seq(-1, -1, -1);
        chk("R2 cap when training enabled", r_cap, 1);
        chk("R4 request cycle", r_req_n, 2);
        chk("R4 request count", r_req_cnt, 1);
        chk("R4 cap at request", r_req_max, 2);
        chk("R6 pass", r_pass, 1);
        chk("R7 speed", r_speed, 2);
        repeat (5) @(negedge clk);
        chk("R7 done held", done, 1);

        // up but training, training ends early
        m_up = 1; m_trn = 1; cur_speed = 4'd3;
        run_seq(3, -1, -1);
        chk("R3 recheck spacing", r_req_n, RC + 3);
        chk("R3 pass after recheck", r_pass, 1);

        // training forever with stall code: rechecks take priority
        m_up = 1; m_trn = 1; rx_valid = 0; ltssm = 6'h0D;
        run_seq(-1, -1, -1);
        chk("R3 stall after recheck budget", r_ov_n, 2 + RMAX * (RC + 1));
        chk("R8 hold length", r_burst, HOLD);
        chk("R5 fail", r_pass, 0);

        // link down with stall code
        m_up = 0; m_trn = 0; rx_valid = 0; ltssm = 6'h0D;
        run_seq(-1, -1, -1);
        chk("R8 immediate override", r_ov_n, 2);
        chk("R8 hold length", r_burst, HOLD);
        chk("R7 fail speed", r_speed, 0);

        // near-miss codes
        m_up = 0; rx_valid = 0; ltssm = 6'h0C;
        run_seq(-1, -1, -1);
        chk("R9 code 0x0C no override", r_ov_cyc, 0);
        chk("R5 timeout cycle", r_done_n, LINK + 2);
        chk("R5 timeout fail", r_pass, 0);
        rx_valid = 1; ltssm = 6'h0D;
        run_seq(-1, -1, -1);
        chk("R9 rx_valid no override", r_ov_cyc, 0);

        // ready exactly in the expiring cycle
        m_up = 0; rx_valid = 1; ltssm = 6'h11; flag_dly = 4; cur_speed = 4'd2;
        run_seq(-1, -1, LINK + 1);
        chk("R5 ready beats timeout", r_req_n, LINK + 2);
        chk("R5 pass at boundary", r_pass, 1);

        // stuck speed-change flag
        m_up = 1; flag_dly = -1;
        run_seq(-1, -1, -1);
        chk("R6 flag timeout cycle", r_done_n, SPDW + 4);
        chk("R6 flag timeout fail", r_pass, 0);
        chk("R7 speed after fail", r_speed, 0);

        // start while busy
        manual = 0; up_dly = 5; flag_dly = 30; cur_speed = 4'd1;
        run_seq(-1, 20, -1);
        chk("R10 request count", r_req_cnt, 1);
        chk("R10 pass", r_pass, 1);

        // random runs
        for (int i = 0; i < 10; i++) begin
            int ud, fd, sp;
            ud = ($urandom_range(0, 5) == 0) ? -1 : int'($urandom_range(0, 150));
            fd = ($urandom_range(0, 5) == 0) ? -1 : int'($urandom_range(1, 80));
            sp = $urandom_range(1, 3);
            up_dly = ud; flag_dly = fd; cur_speed = 4'(sp);
            rx_valid = 1'($urandom_range(0, 1));
            ltssm = 6'($urandom_range(0, 63));
            if (!rx_valid && ltssm == 6'h0D) ltssm = 6'h0E;
            run_seq(-1, -1, -1);
            chk("R6 random pass", r_pass, exp_pass(ud, fd));
            chk("R7 random speed", r_speed, exp_pass(ud, fd) ? sp : 0);
            chk("R4 random request count", r_req_cnt, (ud >= 0) ? 1 : 0);
            chk("R9 random no override", r_ov_cyc, 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule